// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder (Negabit/Posibit Digits)

This block adds two numbers held in a redundant radix-2 signed-digit form in constant time, whatever the operand width. Every digit position carries two bits: a negabit with weight -2·2^j and a posibit with weight +2^j. A digit therefore takes a value in [-2,1]. An operand enters as two N-bit vectors, one holding the negabits and one holding the posibits. The sum leaves in exactly the same form, widened to N+2 digits. The output can therefore be fed straight back into another addition with no conversion step.

The adder works on columns, not on digits. Column c collects every operand bit whose weight is 2^c: the two posibits of digit c and the two negabits of digit c-1. Two fixed-depth stages turn each column into result bits. The first stage splits the column total into a non-negative transfer and a non-positive residue. The second stage absorbs the incoming transfer and emits a non-positive transfer of its own. No signal crosses more than two columns, so the logic depth does not depend on N. An optional register stage, selected by a parameter, captures the result and raises a valid flag one clock after the input is marked valid.

Top module: `sd_adder`

## Requirements
- R1: For any pair of operands, the arithmetic value of the result equals the sum of the arithmetic values of the two operands.
- R2: Operand and result use one encoding. The negabit at position j counts -2^(j+1), the posibit at position j counts +2^j, and a digit is worth (posibit - 2·negabit)·2^j.
- R3: The result has N+2 digits, and digit N+1 (both its negabit and its posibit) is always 0.
- R4: A change to any single operand bit at position i (negabit or posibit) changes only result digits i, i+1 and i+2. All other result digits keep their values.
- R5: Result digits cover the whole set [-2,1], and the encodings are fixed. Posibit 0 set in both operands gives result posibits 0b10 with negabits 0. Negabit 0 set in both gives negabits 0b10 with posibits 0. Negabit 0 set in one operand only gives posibits 0b10 with negabits 0b10. Posibit 0 set in one operand only gives posibits 0b11 with negabits 0b01.
- R6: With the register stage enabled, out_valid is in_valid delayed by one clock, and the result shown belongs to the operands presented with that in_valid. With the register stage disabled, the result and out_valid follow the inputs in the same cycle.
- R7: While rst is high, the registered outputs are cleared: out_valid is 0 and every result bit is 0.
- R8: In registered mode, a cycle with in_valid low leaves the result bits unchanged and drives out_valid to 0, even when the operands change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operands as valid this cycle |
| a_neg | input | N | Negabits of operand A |
| a_pos | input | N | Posibits of operand A |
| b_neg | input | N | Negabits of operand B |
| b_pos | input | N | Posibits of operand B |
| out_valid | output | 1 | Result is valid |
| s_neg | output | N+2 | Negabits of the sum |
| s_pos | output | N+2 | Posibits of the sum |

## Verification
The adder is driven with operands that hold only posibits, only negabits, both at once, opposing signs at the same weight, and single bits at position 0. This separates a fault in the positive-path transfer from one in the negative-path transfer, and it shows whether both bits of a column are weighted correctly. The single-bit cases pin down the exact result encoding for every digit value in [-2,1]. A digit set that collapses to [-1,1], or a wrong transfer direction, then shows up even when the total value happens to agree. Random operand pairs, paired with single-bit flips of the same operand, test whether a change reaches further than two columns, which would mean a hidden carry chain. Reset, idle-cycle hold and the one-cycle valid delay are checked on the registered build, while the combinational build is checked in the same cycle as its inputs.

// File: rtl/sd_adder_pkg.sv
package sd_adder_pkg;

  // Output of the first column stage: transfer to the next column (0 or +1)
  // and the magnitude of the non-positive residue kept in this column (0..2).
  typedef struct packed {
    logic       xfer_up;
    logic [1:0] resid_mag;
  } split_t;

  // Output of the second column stage: the posibit kept at this weight and a
  // flag for a -1 transfer, which becomes the negabit of this digit.
  typedef struct packed {
    logic neg_out;
    logic pos_out;
  } merge_t;

endpackage

// File: rtl/sd_col_split.sv
module sd_col_split
  import sd_adder_pkg::*;
(
  input  logic   pos_a,
  input  logic   pos_b,
  input  logic   neg_a,
  input  logic   neg_b,
  output split_t split
);

  logic signed [3:0] col_val;
  logic signed [3:0] resid;

  always_comb begin
    // column total lies in [-2, 2]
    col_val = 4'(pos_a) + 4'(pos_b) - 4'(neg_a) - 4'(neg_b);
    split.xfer_up = (col_val > 4'sd0);
    // residue = col_val - 2*xfer_up, in [-2, 0]; keep its magnitude
    resid = split.xfer_up ? (4'sd2 - col_val) : (4'sd0 - col_val);
    split.resid_mag = resid[1:0];
  end

endmodule

// File: rtl/sd_col_merge.sv
module sd_col_merge
  import sd_adder_pkg::*;
(
  input  logic       xfer_in,
  input  logic [1:0] resid_mag,
  output merge_t     merge
);

  // interim = xfer_in - resid_mag lies in [-2, 1]
  // split into -1 * neg_out * 2 + pos_out
  always_comb begin
    merge.neg_out = (resid_mag > {1'b0, xfer_in});
    merge.pos_out = xfer_in ^ resid_mag[0];
  end

endmodule

// File: rtl/sd_out_stage.sv
module sd_out_stage #(
  parameter int W       = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] d_neg,
  input  logic [W-1:0] d_pos,
  output logic         out_valid,
  output logic [W-1:0] q_neg,
  output logic [W-1:0] q_pos
);

  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] neg_q;
      logic [W-1:0] pos_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          neg_q <= '0;
          pos_q <= '0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) begin
            neg_q <= d_neg;
            pos_q <= d_pos;
          end
        end
      end

      assign out_valid = vld_q;
      assign q_neg     = neg_q;
      assign q_pos     = pos_q;
    end else begin : g_comb
      logic clk_unused;
      assign clk_unused = clk;
      assign out_valid  = in_valid & ~rst;
      assign q_neg      = d_neg;
      assign q_pos      = d_pos;
    end
  endgenerate

endmodule

// File: rtl/sd_adder.sv
module sd_adder
  import sd_adder_pkg::*;
#(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] a_neg,
  input  logic [N-1:0] a_pos,
  input  logic [N-1:0] b_neg,
  input  logic [N-1:0] b_pos,
  output logic         out_valid,
  output logic [N+1:0] s_neg,
  output logic [N+1:0] s_pos
);

  localparam int NCOL = N + 1;   // columns holding operand bits
  localparam int OW   = N + 2;   // result digits

  // Column-aligned operand bits: column c takes posibits of digit c and
  // negabits of digit c-1, both worth 2^c.
  logic [NCOL-1:0] col_pa, col_pb, col_na, col_nb;

  assign col_pa = {1'b0, a_pos};
  assign col_pb = {1'b0, b_pos};
  assign col_na = {a_neg, 1'b0};
  assign col_nb = {b_neg, 1'b0};

  split_t [NCOL-1:0] split;
  merge_t [NCOL-1:0] merge;
  logic   [NCOL:0]   xfer;       // xfer[c] enters column c
  logic   [OW-1:0]   sum_neg, sum_pos;

  assign xfer[0] = 1'b0;

  generate
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      sd_col_split u_split (
        .pos_a (col_pa[c]),
        .pos_b (col_pb[c]),
        .neg_a (col_na[c]),
        .neg_b (col_nb[c]),
        .split (split[c])
      );

      assign xfer[c+1] = split[c].xfer_up;

      sd_col_merge u_merge (
        .xfer_in   (xfer[c]),
        .resid_mag (split[c].resid_mag),
        .merge     (merge[c])
      );

      assign sum_pos[c] = merge[c].pos_out;
      assign sum_neg[c] = merge[c].neg_out;
    end
  endgenerate

  // Top column: only an incoming transfer, which cannot be negative.
  assign sum_pos[OW-1] = xfer[NCOL];
  assign sum_neg[OW-1] = 1'b0;

  sd_out_stage #(
    .W       (OW),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .d_neg     (sum_neg),
    .d_pos     (sum_pos),
    .out_valid (out_valid),
    .q_neg     (s_neg),
    .q_pos     (s_pos)
  );

endmodule

// File: rtl/sd_adder_chk.sv
module sd_adder_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [N-1:0] a_neg,
  input logic [N-1:0] a_pos,
  input logic [N-1:0] b_neg,
  input logic [N-1:0] b_pos,
  input logic         out_valid,
  input logic [N+1:0] s_neg,
  input logic [N+1:0] s_pos
);

  localparam int VW = N + 6;

  function automatic logic signed [VW-1:0] op_value(input logic [N-1:0] ng,
                                                     input logic [N-1:0] ps);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      if (ps[j]) acc = acc + (VW'(1) <<< j);
      if (ng[j]) acc = acc - (VW'(1) <<< (j + 1));
    end
    return acc;
  endfunction

  function automatic logic signed [VW-1:0] res_value(input logic [N+1:0] ng,
                                                      input logic [N+1:0] ps);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int j = 0; j < N + 2; j++) begin
      if (ps[j]) acc = acc + (VW'(1) <<< j);
      if (ng[j]) acc = acc - (VW'(1) <<< (j + 1));
    end
    return acc;
  endfunction

  logic signed [VW-1:0] in_sum, out_val;
  assign in_sum  = op_value(a_neg, a_pos) + op_value(b_neg, b_pos);
  assign out_val = res_value(s_neg, s_pos);

  // R3
  top_digit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (s_neg[N+1] == 1'b0 && s_pos[N+1] == 1'b0));

  generate
    if (REG_OUT) begin : g_reg_chk
      // R1
      sum_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_val == $past(in_sum));
      // R6
      valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));
      // R7
      reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && s_neg == '0 && s_pos == '0));
      // R8
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(s_neg) && $stable(s_pos)));
    end else begin : g_comb_chk
      // R1
      sum_value_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> out_val == in_sum);
      // R6
      valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid);
    end
  endgenerate

endmodule

bind sd_adder sd_adder_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_neg     (a_neg),
  .a_pos     (a_pos),
  .b_neg     (b_neg),
  .b_pos     (b_pos),
  .out_valid (out_valid),
  .s_neg     (s_neg),
  .s_pos     (s_pos)
);

// File: tb/sd_adder_test.sv
`timescale 1ns/1ps
module sd_adder_test;

  localparam int N    = 8;
  localparam int OW   = N + 2;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  a_neg = '0, a_pos = '0, b_neg = '0, b_pos = '0;
  logic          out_valid, c_valid;
  logic [OW-1:0] s_neg, s_pos, c_neg, c_pos;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  sd_adder #(.N(N), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_neg(a_neg), .a_pos(a_pos), .b_neg(b_neg), .b_pos(b_pos),
    .out_valid(out_valid), .s_neg(s_neg), .s_pos(s_pos)
  );

  sd_adder #(.N(N), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_neg(a_neg), .a_pos(a_pos), .b_neg(b_neg), .b_pos(b_pos),
    .out_valid(c_valid), .s_neg(c_neg), .s_pos(c_pos)
  );

  // stimulus {a_neg, a_pos, b_neg, b_pos} and hand-computed sum values
  localparam logic [4*N-1:0] STIM [NVEC] = '{
    32'h00_00_00_00,
    32'h00_FF_00_FF,
    32'hFF_00_FF_00,
    32'hFF_FF_00_00,
    32'h00_01_00_01,
    32'h01_00_01_00,
    32'h00_80_80_00,
    32'h00_55_55_00,
    32'hAA_0F_0F_F0,
    32'h00_7F_00_01
  };
  localparam int EXPV [NVEC] = '{0, 510, -1020, -255, 2, -4, -128, -85, -115, 128};

  function automatic int op_val(input logic [N-1:0] ng, input logic [N-1:0] ps);
    int acc = 0;
    for (int j = 0; j < N; j++) acc += int'(ps[j]) * (1 << j) - int'(ng[j]) * (2 << j);
    return acc;
  endfunction

  function automatic int res_val(input logic [OW-1:0] ng, input logic [OW-1:0] ps);
    int acc = 0;
    for (int j = 0; j < OW; j++) acc += int'(ps[j]) * (1 << j) - int'(ng[j]) * (2 << j);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4*N-1:0] v, input logic vld);
    {a_neg, a_pos, b_neg, b_pos} = v;
    in_valid = vld;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [OW-1:0] hold_neg, hold_pos, base_neg, base_pos;
    logic [4*N-1:0] rv;
    int k;

    // reset state, R7
    @(negedge clk);
    drive(32'hFF_FF_FF_FF, 1'b1);
    @(negedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R7 valid in reset", int'(out_valid), 0);
    check(s_neg == '0 && s_pos == '0, "R7 data in reset", int'({s_neg, s_pos}), 0);
    drive('0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // vector table: R1, R2, R3, R6
    for (int i = 0; i < NVEC; i++) begin
      drive(STIM[i], 1'b1);
      #1;
      check(res_val(c_neg, c_pos) == EXPV[i], "R2 comb value", res_val(c_neg, c_pos), EXPV[i]);
      check(c_valid == 1'b1, "R6 comb valid", int'(c_valid), 1);
      @(negedge clk);
      check(out_valid == 1'b1, "R6 reg valid", int'(out_valid), 1);
      check(res_val(s_neg, s_pos) == EXPV[i], "R1 reg value", res_val(s_neg, s_pos), EXPV[i]);
      check(s_neg[OW-1] == 1'b0 && s_pos[OW-1] == 1'b0, "R3 top digit",
            int'({s_neg[OW-1], s_pos[OW-1]}), 0);
    end

    // exact encodings over the digit set, R5
    drive(32'h00_01_00_01, 1'b1); #1;
    check(c_pos == 10'b10 && c_neg == 10'b0, "R5 digit +1", int'({c_neg, c_pos}), 2);
    drive(32'h01_00_01_00, 1'b1); #1;
    check(c_neg == 10'b10 && c_pos == 10'b0, "R5 digit -2", int'({c_neg, c_pos}), 2 << OW);
    drive(32'h01_00_00_00, 1'b1); #1;
    check(c_neg == 10'b10 && c_pos == 10'b10, "R5 digit -1", int'({c_neg, c_pos}),
          (2 << OW) | 2);
    drive(32'h00_01_00_00, 1'b1); #1;
    check(c_neg == 10'b01 && c_pos == 10'b11, "R5 posibit only", int'({c_neg, c_pos}),
          (1 << OW) | 3);
    @(negedge clk);

    // idle cycle hold, R8
    hold_neg = s_neg; hold_pos = s_pos;
    drive(32'h5A_A5_C3_3C, 1'b0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid low when idle", int'(out_valid), 0);
    check(s_neg == hold_neg && s_pos == hold_pos, "R8 data held",
          int'({s_neg, s_pos}), int'({hold_neg, hold_pos}));
    check(c_valid == 1'b0, "R6 comb valid low", int'(c_valid), 0);

    // random operands, R1 on both builds
    for (int t = 0; t < 300; t++) begin
      rv = $urandom();
      drive(rv, 1'b1);
      #1;
      check(res_val(c_neg, c_pos) == op_val(rv[31:24], rv[23:16]) + op_val(rv[15:8], rv[7:0]),
            "R1 comb random", res_val(c_neg, c_pos),
            op_val(rv[31:24], rv[23:16]) + op_val(rv[15:8], rv[7:0]));
      @(negedge clk);
      check(res_val(s_neg, s_pos) == op_val(rv[31:24], rv[23:16]) + op_val(rv[15:8], rv[7:0]),
            "R1 reg random", res_val(s_neg, s_pos),
            op_val(rv[31:24], rv[23:16]) + op_val(rv[15:8], rv[7:0]));
    end

    // single-bit flip locality, R4
    for (int t = 0; t < 64; t++) begin
      rv = $urandom();
      drive(rv, 1'b1); #1;
      base_neg = c_neg; base_pos = c_pos;
      k = $urandom_range(4 * N - 1);
      rv[k] = ~rv[k];
      drive(rv, 1'b1); #1;
      for (int j = 0; j < OW; j++) begin
        if (j < (k % N) || j > (k % N) + 2)
          check(c_neg[j] == base_neg[j] && c_pos[j] == base_pos[j], "R4 locality",
                int'({c_neg[j], c_pos[j]}), int'({base_neg[j], base_pos[j]}));
      end
      @(negedge clk);
    end

    drive('0, 1'b0);
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule